// File: doc/BRIEF.md
# Locked Configuration Port with Banked Logical-Device Registers

This block is the configuration side of a legacy multi-function I/O controller, as seen from a byte-wide I/O bus. Two adjacent addresses form an index/data pair: the index port selects a configuration register and the data port reads or writes it. The controller ignores configuration traffic until the host writes a fixed key sequence to the index port. Another fixed action locks it again.

A parameter picks one of two key styles. The four-byte style ends on a byte that depends on which of the two base addresses the port decodes, and it locks again through a register write. The two-byte style locks again when a single byte is written to the index port. Registers below 0x30 are global: chip identity, the logical-device selector and the lock-exit register. Registers from 0x30 up belong to the logical device that the selector names. Each device holds an enable byte, two 16-bit I/O base addresses, an interrupt line and a DMA channel.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked and `cfg_active` is 0. The device selector (register 0x07) is 0, the index register is 0, and every banked register of every device reads 0.
- R2: While locked, data-port reads return 0xFF and data-port writes change nothing. An index-port write only feeds the key matcher and leaves the index register unchanged.
- R3: Four-byte style: writing 0x87, 0x01, 0x55 and then a final byte to the index port unlocks the port. The final byte is 0x55 when the base is 0x2E (ALT_BASE=0) and 0xAA when the base is 0x4E (ALT_BASE=1). The other final value does not unlock.
- R4: A key byte that does not match restarts matching. If that byte is 0x87, it counts as the first byte of a new attempt.
- R5: Four-byte style: writing data 0x02 to register 0x02 locks the port. Any other value written there leaves the port unlocked.
- R6: Two-byte style: two consecutive index writes of 0x87 unlock the port. An index write of 0xAA while unlocked locks the port and leaves the index register unchanged.
- R7: Register 0x20 returns CHIP_ID[15:8] and register 0x21 returns CHIP_ID[7:0] in both styles. Register 0x22 returns CHIP_REV in the four-byte style and 0 in the two-byte style.
- R8: Register 0x07 is an 8-bit read/write device selector. Every other global register from 0x00 to 0x2F reads as fixed: 0x00 unless it is an identity byte. Writes to those registers have no effect.
- R9: For each device number below NUM_LDN, the registers at 0x30, 0x60, 0x61, 0x62, 0x63, 0x70 and 0x74 store 8 bits independently of every other device. Every other banked address reads 0 and ignores writes.
- R10: When the selector holds a number of NUM_LDN or more (including 0xFF), banked reads return 0 and banked writes change no device.
- R11: `cfg_active` is 1 exactly while the port is unlocked. Reading the index port while unlocked returns the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Bus write strobe, one cycle per byte |
| io_rd | input | 1 | Bus read strobe |
| io_sel | input | 1 | Port offset: 0 = index port, 1 = data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from io_sel and state |
| cfg_active | output | 1 | High while configuration access is unlocked |

## Verification
The hardest state to reach from the ports is the key matcher partway through a sequence when a byte breaks it, in particular when the breaking byte is itself the first key byte. The bench drives sequences that break at different positions, with and without a restarting 0x87, and only `cfg_active` shows the result. A second hard point is proving that a write was ignored. The bench does this through the normal interface: it leaves the index pointing at a banked register, locks, writes the data port, unlocks, and reads the same register back. Every device number and every banked slot is filled with a value computed from the device number and slot, then all of them are read back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [0:0] {KEY_FOUR = 1'b0, KEY_DOUBLE = 1'b1} key_style_e;

  localparam logic [7:0] REG_EXIT   = 8'h02;
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ID_HI  = 8'h20;
  localparam logic [7:0] REG_ID_LO  = 8'h21;
  localparam logic [7:0] REG_REV    = 8'h22;
  localparam logic [7:0] BANK_FLOOR = 8'h30;
  localparam logic [7:0] EXIT_CODE  = 8'h02;
  localparam logic [7:0] LEAVE_BYTE = 8'hAA;
  localparam int         SLOT_CNT   = 8;
  localparam logic [2:0] SLOT_NONE  = 3'd7;

  function automatic int key_len(key_style_e s);
    return (s == KEY_FOUR) ? 4 : 2;
  endfunction

  // expected byte at a given position of the unlock key
  function automatic logic [7:0] key_byte(key_style_e s, logic alt_base, int pos);
    if (s == KEY_DOUBLE) return 8'h87;
    case (pos)
      0:       return 8'h87;
      1:       return 8'h01;
      2:       return 8'h55;
      default: return alt_base ? 8'hAA : 8'h55;
    endcase
  endfunction

  // banked address to storage slot; SLOT_NONE = not backed by storage
  function automatic logic [2:0] slot_of(logic [7:0] a);
    case (a)
      8'h30:   return 3'd0;
      8'h60:   return 3'd1;
      8'h61:   return 3'd2;
      8'h62:   return 3'd3;
      8'h63:   return 3'd4;
      8'h70:   return 3'd5;
      8'h74:   return 3'd6;
      default: return SLOT_NONE;
    endcase
  endfunction

  function automatic logic [7:0] glob_read(key_style_e s, logic [15:0] id,
                                           logic [7:0] rev, logic [7:0] ldn,
                                           logic [7:0] a);
    case (a)
      REG_LDN:   return ldn;
      REG_ID_HI: return id[15:8];
      REG_ID_LO: return id[7:0];
      REG_REV:   return (s == KEY_FOUR) ? rev : 8'h00;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
  import sio_cfg_pkg::*;
#(
  parameter key_style_e KEY_STYLE = KEY_FOUR,
  parameter bit         ALT_BASE  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       unlocked
);
  localparam int KLEN = key_len(KEY_STYLE);
  localparam int PW   = $clog2(KLEN + 1);

  logic [PW-1:0] pos_q;
  logic          unl_q;
  logic          hit_w;
  logic          restart_w;
  logic          last_w;

  assign hit_w     = (wdata == key_byte(KEY_STYLE, ALT_BASE, int'(pos_q)));
  assign restart_w = (wdata == key_byte(KEY_STYLE, ALT_BASE, 0));
  assign last_w    = (pos_q == PW'(KLEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      unl_q <= 1'b0;
    end else if (unl_q) begin
      if (exit_req) begin
        unl_q <= 1'b0;
        pos_q <= '0;
      end
    end else if (idx_wr) begin
      if (hit_w) begin
        if (last_w) begin
          unl_q <= 1'b1;
          pos_q <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else begin
        pos_q <= restart_w ? PW'(1) : '0;
      end
    end
  end

  assign unlocked = unl_q;

  // R3 / R6: unlocking only follows an index-port write
  a_r3_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(idx_wr));
  // R5 / R6: locking only follows an exit request
  a_r5_lock_needs_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unl_q) |-> $past(exit_req));

endmodule

// File: rtl/sio_glob_regs.sv
module sio_glob_regs
  import sio_cfg_pkg::*;
#(
  parameter key_style_e  KEY_STYLE = KEY_FOUR,
  parameter logic [15:0] CHIP_ID   = 16'hA51C,
  parameter logic [7:0]  CHIP_REV  = 8'h3B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic       glob_we,
  input  logic [7:0] wdata,
  output logic [7:0] index_q,
  output logic [7:0] ldn_q,
  output logic [7:0] glob_rdata
);
  logic ldn_we;

  assign ldn_we = glob_we && (index_q == REG_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (idx_we) index_q <= wdata;
      if (ldn_we) ldn_q   <= wdata;
    end
  end

  assign glob_rdata = glob_read(KEY_STYLE, CHIP_ID, CHIP_REV, ldn_q, index_q);

  // R8: the selector only moves on a write aimed at it
  a_r8_ldn_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldn_q) |-> $past(ldn_we));

endmodule

// File: rtl/sio_ldn_bank.sv
module sio_ldn_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] ldn,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int LW = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  logic             in_range;
  logic [2:0]       slot;
  logic             slot_ok;
  logic [7:0]       dev_rd [NUM_LDN];
  logic [NUM_LDN-1:0] commit_vec;

  assign in_range = (int'(ldn) < NUM_LDN);
  assign slot     = slot_of(index);
  assign slot_ok  = (slot != SLOT_NONE);

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
    logic [7:0] regs [SLOT_CNT];
    assign commit_vec[g] = we && slot_ok && (int'(ldn) == g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SLOT_CNT; s++) regs[s] <= 8'h00;
      end else if (commit_vec[g]) begin
        regs[slot] <= wdata;
      end
    end

    assign dev_rd[g] = slot_ok ? regs[slot] : 8'h00;
  end

  assign rdata = in_range ? dev_rd[ldn[LW-1:0]] : 8'h00;

  // R9: a banked write lands in at most one device
  a_r9_single_device: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_vec));
  // R10: no device is written while the selector is out of range
  a_r10_range_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !in_range) |-> (commit_vec == '0));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter key_style_e  KEY_STYLE = KEY_FOUR,
  parameter bit          ALT_BASE  = 1'b0,
  parameter int          NUM_LDN   = 16,
  parameter logic [15:0] CHIP_ID   = 16'hA51C,
  parameter logic [7:0]  CHIP_REV  = 8'h3B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic       io_sel,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cfg_active
);
  logic       unlocked;
  logic       idx_port_wr, dat_port_wr;
  logic       exit_req, key_feed;
  logic       idx_we, dat_we, glob_we, bank_we;
  logic [7:0] index_q, ldn_q, glob_rdata, bank_rdata;
  logic       in_bank;

  assign idx_port_wr = io_wr && !io_sel;
  assign dat_port_wr = io_wr &&  io_sel;
  assign key_feed    = idx_port_wr && !unlocked;

  if (KEY_STYLE == KEY_FOUR) begin : g_exit_reg
    assign exit_req = unlocked && dat_port_wr && (index_q == REG_EXIT)
                      && (io_wdata == EXIT_CODE);
  end else begin : g_exit_idx
    assign exit_req = unlocked && idx_port_wr && (io_wdata == LEAVE_BYTE);
  end

  assign in_bank = (index_q >= BANK_FLOOR);
  assign idx_we  = unlocked && idx_port_wr && !exit_req;
  assign dat_we  = unlocked && dat_port_wr;
  assign glob_we = dat_we && !in_bank;
  assign bank_we = dat_we &&  in_bank;

  sio_key_unlock #(.KEY_STYLE(KEY_STYLE), .ALT_BASE(ALT_BASE)) key_i (
    .clk(clk), .rst_n(rst_n), .idx_wr(key_feed), .wdata(io_wdata),
    .exit_req(exit_req), .unlocked(unlocked));

  sio_glob_regs #(.KEY_STYLE(KEY_STYLE), .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) glob_i (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .glob_we(glob_we),
    .wdata(io_wdata), .index_q(index_q), .ldn_q(ldn_q), .glob_rdata(glob_rdata));

  sio_ldn_bank #(.NUM_LDN(NUM_LDN)) bank_i (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .ldn(ldn_q), .index(index_q),
    .wdata(io_wdata), .rdata(bank_rdata));

  always_comb begin
    if (!unlocked)    io_rdata = 8'hFF;
    else if (!io_sel) io_rdata = index_q;
    else if (in_bank) io_rdata = bank_rdata;
    else              io_rdata = glob_rdata;
  end

  assign cfg_active = unlocked;

  // R2: while locked the index pointer and the selector hold still
  a_r2_locked_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(index_q));
  a_r2_locked_ldn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ldn_q));
  // R6: the leaving byte never lands in the index register
  a_r6_leave_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> $stable(index_q));

endmodule

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;
  import sio_cfg_pkg::*;

  localparam logic [15:0] TB_ID  = 16'hA51C;
  localparam logic [7:0]  TB_REV = 8'h3B;
  localparam int          TB_LDN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       wr_x   [2];
  logic       rd_x   [2];
  logic       sel_x  [2];
  logic [7:0] wd_x   [2];
  logic [7:0] rdat_x [2];
  logic       act_x  [2];

  int compared = 0;
  int mismatched = 0;

  // dut_i: four-byte key, base 0x4E; dut_b_i: two-byte key
  sio_cfg_port #(.KEY_STYLE(KEY_FOUR), .ALT_BASE(1'b1), .NUM_LDN(TB_LDN),
                 .CHIP_ID(TB_ID), .CHIP_REV(TB_REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(wr_x[0]), .io_rd(rd_x[0]), .io_sel(sel_x[0]),
    .io_wdata(wd_x[0]), .io_rdata(rdat_x[0]), .cfg_active(act_x[0]));

  sio_cfg_port #(.KEY_STYLE(KEY_DOUBLE), .ALT_BASE(1'b0), .NUM_LDN(TB_LDN),
                 .CHIP_ID(TB_ID), .CHIP_REV(TB_REV)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .io_wr(wr_x[1]), .io_rd(rd_x[1]), .io_sel(sel_x[1]),
    .io_wdata(wd_x[1]), .io_rdata(rdat_x[1]), .cfg_active(act_x[1]));

  function automatic logic [7:0] pat(int l, int k);
    return 8'((l * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] bank_addr(int k);
    case (k)
      0: return 8'h30; 1: return 8'h60; 2: return 8'h61; 3: return 8'h62;
      4: return 8'h63; 5: return 8'h70; default: return 8'h74;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bwr(input int d, input logic a, input logic [7:0] v);
    @(negedge clk);
    wr_x[d] = 1'b1; sel_x[d] = a; wd_x[d] = v;
    @(negedge clk);
    wr_x[d] = 1'b0;
  endtask

  task automatic brd(input int d, input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_x[d] = 1'b1; sel_x[d] = a;
    #1 v = rdat_x[d];
    @(negedge clk);
    rd_x[d] = 1'b0;
  endtask

  task automatic cfg_w(input int d, input logic [7:0] r, input logic [7:0] v);
    bwr(d, 1'b0, r);
    bwr(d, 1'b1, v);
  endtask

  task automatic cfg_r(input int d, input logic [7:0] r, output logic [7:0] v);
    bwr(d, 1'b0, r);
    brd(d, 1'b1, v);
  endtask

  task automatic unlock(input int d);
    if (d == 0) begin
      bwr(0, 1'b0, 8'h87); bwr(0, 1'b0, 8'h01); bwr(0, 1'b0, 8'h55); bwr(0, 1'b0, 8'hAA);
    end else begin
      bwr(1, 1'b0, 8'h87); bwr(1, 1'b0, 8'h87);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    for (int d = 0; d < 2; d++) begin
      wr_x[d] = 0; rd_x[d] = 0; sel_x[d] = 0; wd_x[d] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 active A", {7'd0, act_x[0]}, 8'h00);
    check("R1 active B", {7'd0, act_x[1]}, 8'h00);
    brd(0, 1'b1, v); check("R2 locked read A", v, 8'hFF);
    unlock(1);
    check("R6 unlock B", {7'd0, act_x[1]}, 8'h01);
    brd(1, 1'b0, v); check("R1 index zero", v, 8'h00);
    cfg_r(1, 8'h07, v); check("R1 ldn zero", v, 8'h00);
    cfg_w(1, 8'h07, 8'h03);
    cfg_r(1, 8'h70, v); check("R1 bank zero", v, 8'h00);

    // R2 locked data write ignored, index untouched by key bytes
    bwr(1, 1'b0, 8'h30);
    bwr(1, 1'b0, 8'hAA);
    check("R6 leave B", {7'd0, act_x[1]}, 8'h00);
    bwr(1, 1'b1, 8'h77);
    brd(1, 1'b1, v); check("R2 locked read B", v, 8'hFF);
    unlock(1);
    brd(1, 1'b0, v); check("R6 index kept across leave", v, 8'h30);
    brd(1, 1'b1, v); check("R2 locked write ignored", v, 8'h00);

    // R6 broken double key
    bwr(1, 1'b0, 8'hAA);
    bwr(1, 1'b0, 8'h87); bwr(1, 1'b0, 8'h55); bwr(1, 1'b0, 8'h87);
    check("R4 broken double key", {7'd0, act_x[1]}, 8'h00);
    bwr(1, 1'b0, 8'h87);
    check("R4 restart double key", {7'd0, act_x[1]}, 8'h01);

    // R7 identity, two-byte style
    cfg_r(1, 8'h20, v); check("R7 B id hi", v, TB_ID[15:8]);
    cfg_r(1, 8'h21, v); check("R7 B id lo", v, TB_ID[7:0]);
    cfg_r(1, 8'h22, v); check("R7 B rev zero", v, 8'h00);

    // R3 wrong final byte for base 0x4E
    bwr(0, 1'b0, 8'h87); bwr(0, 1'b0, 8'h01); bwr(0, 1'b0, 8'h55); bwr(0, 1'b0, 8'h55);
    check("R3 wrong final byte", {7'd0, act_x[0]}, 8'h00);
    unlock(0);
    check("R3 key accepted", {7'd0, act_x[0]}, 8'h01);

    // R5 exit register
    cfg_w(0, 8'h02, 8'h01);
    check("R5 other value keeps open", {7'd0, act_x[0]}, 8'h01);
    cfg_w(0, 8'h02, 8'h02);
    check("R5 exit", {7'd0, act_x[0]}, 8'h00);

    // R4 restart with 0x87 mid-sequence
    bwr(0, 1'b0, 8'h87); bwr(0, 1'b0, 8'h01); bwr(0, 1'b0, 8'h87);
    bwr(0, 1'b0, 8'h01); bwr(0, 1'b0, 8'h55); bwr(0, 1'b0, 8'hAA);
    check("R4 restart counts 87", {7'd0, act_x[0]}, 8'h01);
    cfg_w(0, 8'h02, 8'h02);
    bwr(0, 1'b0, 8'h87); bwr(0, 1'b0, 8'h01); bwr(0, 1'b0, 8'h33);
    bwr(0, 1'b0, 8'h01); bwr(0, 1'b0, 8'h55); bwr(0, 1'b0, 8'hAA);
    check("R4 broken key stays locked", {7'd0, act_x[0]}, 8'h00);
    unlock(0);

    // R11 index port readback
    bwr(0, 1'b0, 8'h5C);
    brd(0, 1'b0, v); check("R11 index readback", v, 8'h5C);

    // R8 global sweep: fill with ones, expect fixed values
    for (int a = 0; a < 8'h30; a++)
      if (a != 8'h02 && a != 8'h07) cfg_w(0, 8'(a), 8'hFF);
    for (int a = 0; a < 8'h30; a++) begin
      logic [7:0] e;
      e = (a == 8'h20) ? TB_ID[15:8] : (a == 8'h21) ? TB_ID[7:0] :
          (a == 8'h22) ? TB_REV : 8'h00;
      cfg_r(0, 8'(a), v); check($sformatf("R8 R7 global %02h", a), v, e);
    end
    cfg_w(0, 8'h07, 8'h0A);
    cfg_r(0, 8'h07, v); check("R8 ldn write", v, 8'h0A);

    // R9 fill every slot of every device, then read back
    for (int l = 0; l < TB_LDN; l++) begin
      cfg_w(0, 8'h07, 8'(l));
      for (int k = 0; k < 7; k++) cfg_w(0, bank_addr(k), pat(l, k));
      cfg_w(0, 8'h31, 8'hEE);
      cfg_w(0, 8'h75, 8'hEE);
    end
    for (int l = 0; l < TB_LDN; l++) begin
      cfg_w(0, 8'h07, 8'(l));
      for (int k = 0; k < 7; k++) begin
        cfg_r(0, bank_addr(k), v);
        check($sformatf("R9 ldn %0d slot %02h", l, bank_addr(k)), v, pat(l, k));
      end
      cfg_r(0, 8'h31, v); check("R9 unbacked 31", v, 8'h00);
      cfg_r(0, 8'h75, v); check("R9 unbacked 75", v, 8'h00);
    end

    // R10 out-of-range selectors
    cfg_w(0, 8'h07, 8'hFF);
    cfg_w(0, 8'h60, 8'h99);
    cfg_r(0, 8'h60, v); check("R10 ldn FF read", v, 8'h00);
    cfg_w(0, 8'h07, 8'(TB_LDN));
    cfg_w(0, 8'h70, 8'h44);
    cfg_r(0, 8'h70, v); check("R10 ldn limit read", v, 8'h00);
    cfg_w(0, 8'h07, 8'h00);
    cfg_r(0, 8'h60, v); check("R10 dev0 untouched 60", v, pat(0, 1));
    cfg_r(0, 8'h70, v); check("R10 dev0 untouched 70", v, pat(0, 5));
    cfg_w(0, 8'h07, 8'(TB_LDN - 1));
    cfg_r(0, 8'h70, v); check("R10 top dev untouched", v, pat(TB_LDN - 1, 5));

    summary();
  end

endmodule